// File: doc/BRIEF.md
# Fine Phase Step Tracker with Overflow Status

This block keeps a signed count of fine phase steps, where one step stands for 1/256 of a clock period. Each cycle in which the step strobe is high moves the count by one, up or down as the direction bit says. Software or a control loop uses the count to know where the phase sits. It does not have to rely on the overflow flag, which raises a status whenever the count has gone past the legal window of the selected mode.

Three windows are supported. Centered mode allows -255 to +255. Positive mode allows 0 to +255. Direct mode allows 0 to +1023. The count stops one step past the window, so repeated requests in the same direction never wrap. Once the flag rises it stays high for a minimum hold time. It drops only after that time has run out and the count is back inside the window, so it can later rise again.

The mode pins are sampled only while reset is held. Changing them during normal operation does nothing until the next reset.

Top module: `phs_ovf_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `phase_val` = 0 and `ovf_flag` = 0.
- R2: With `mode_sel` = 2'b00 (or 2'b11, which aliases it) latched, the legal window is -255..+255. A step that moves the count to +256 or -256 raises `ovf_flag` at the same edge that updates `phase_val`.
- R3: With `mode_sel` = 2'b01 latched, the legal window is 0..+255. Incrementing to +256 raises the flag. A decrement at 0 leaves the count at 0 and does not raise the flag.
- R4: With `mode_sel` = 2'b10 latched, the legal window is 0..+1023. Decrementing from 0 to -1, or incrementing to +1024, raises the flag.
- R5: The count stays between one step below the window (0 in positive mode) and one step above it. A request that would go further leaves it unchanged.
- R6: Once `ovf_flag` rises it stays high for at least 40 consecutive cycles, even if the count returns inside the window.
- R7: After the hold time, the flag falls at the first edge at which the count is inside the window. It stays high for as long as the count is outside the window.
- R8: `mode_sel` is captured only while `rst` is high. Changes while `rst` is low have no effect on limits.
- R9: `step_en` = 0 leaves the count unchanged. With `step_en` = 1, `step_up` = 1 adds one and `step_up` = 0 subtracts one (subject to R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the mode |
| mode_sel | input | 2 | Window select: 00 centered, 01 positive, 10 direct, 11 centered |
| step_en | input | 1 | One step request per cycle while high |
| step_up | input | 1 | Step direction: 1 increment, 0 decrement |
| phase_val | output | VAL_W (12) | Signed current step count |
| ovf_flag | output | 1 | Overflow status with minimum hold |

## Verification
The assertions check the following on every cycle:
- an idle cycle leaves the count unchanged, and a step moves it by no more than one;
- the count never leaves its saturation bounds;
- any out-of-window count comes with the flag raised;
- a raised flag is not dropped before 40 cycles;
- the latched mode never changes outside reset.

Only the bench scenarios can show the following:
- the exact edge at which the flag rises at each mode's boundary;
- the exact cycle at which it falls after the hold;
- the clamp at zero in positive mode;
- that a mode change on the pins during running is really ignored.

// File: rtl/phs_pkg.sv
package phs_pkg;

    localparam int PHS_VAL_W = 12;

    typedef logic signed [PHS_VAL_W-1:0] phs_val_t;

    typedef enum logic [1:0] {
        PM_CENTER   = 2'b00,
        PM_POSITIVE = 2'b01,
        PM_DIRECT   = 2'b10,
        PM_CENTER_B = 2'b11
    } phs_mode_e;

    // lo..hi is the legal window; floor..ceil is the saturation range
    typedef struct packed {
        phs_val_t lo;
        phs_val_t hi;
        phs_val_t floor;
        phs_val_t ceil;
    } phs_bounds_t;

    function automatic phs_bounds_t phs_bounds(input phs_mode_e m,
                                               input int ctr_lim,
                                               input int pos_lim,
                                               input int dir_lim);
        phs_bounds_t b;
        case (m)
            PM_POSITIVE: begin
                b.lo    = phs_val_t'(0);
                b.hi    = phs_val_t'(pos_lim);
                b.floor = phs_val_t'(0);
                b.ceil  = phs_val_t'(pos_lim + 1);
            end
            PM_DIRECT: begin
                b.lo    = phs_val_t'(0);
                b.hi    = phs_val_t'(dir_lim);
                b.floor = phs_val_t'(-1);
                b.ceil  = phs_val_t'(dir_lim + 1);
            end
            default: begin
                b.lo    = phs_val_t'(-ctr_lim);
                b.hi    = phs_val_t'(ctr_lim);
                b.floor = phs_val_t'(-ctr_lim - 1);
                b.ceil  = phs_val_t'(ctr_lim + 1);
            end
        endcase
        return b;
    endfunction

    function automatic logic phs_outside(input phs_val_t v, input phs_bounds_t b);
        return (v < b.lo) || (v > b.hi);
    endfunction

endpackage

// File: rtl/phs_limit_sel.sv
module phs_limit_sel
    import phs_pkg::*;
#(
    parameter int CTR_LIM = 255,
    parameter int POS_LIM = 255,
    parameter int DIR_LIM = 1023
) (
    input  phs_mode_e   mode,
    output phs_bounds_t bounds
);
    always_comb begin
        bounds = phs_bounds(mode, CTR_LIM, POS_LIM, DIR_LIM);
    end
endmodule

// File: rtl/phs_step_unit.sv
module phs_step_unit
    import phs_pkg::*;
(
    input  phs_val_t    cur,
    input  logic        en,
    input  logic        up,
    input  phs_bounds_t bounds,
    output phs_val_t    nxt,
    output logic        nxt_outside
);
    always_comb begin
        nxt = cur;
        if (en) begin
            if (up) begin
                if (cur < bounds.ceil) nxt = cur + phs_val_t'(1);
            end else begin
                if (cur > bounds.floor) nxt = cur - phs_val_t'(1);
            end
        end
        nxt_outside = phs_outside(nxt, bounds);
    end
endmodule

// File: rtl/phs_hold_ctrl.sv
module phs_hold_ctrl #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic nxt_outside,
    output logic flag
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            hold_cnt <= '0;
        end else if (!flag) begin
            if (nxt_outside) begin
                flag     <= 1'b1;
                hold_cnt <= RELOAD;
            end
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else if (!nxt_outside) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/phs_ovf_tracker.sv
module phs_ovf_tracker
    import phs_pkg::*;
#(
    parameter int VAL_W    = PHS_VAL_W,
    parameter int CTR_LIM  = 255,
    parameter int POS_LIM  = 255,
    parameter int DIR_LIM  = 1023,
    parameter int HOLD_CYC = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             step_en,
    input  logic             step_up,
    output logic [VAL_W-1:0] phase_val,
    output logic             ovf_flag
);
    phs_mode_e   mode_q;
    phs_bounds_t bounds;
    phs_val_t    val_q;
    phs_val_t    val_nxt;
    logic        nxt_outside;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= phs_mode_e'(mode_sel);
            val_q  <= '0;
        end else begin
            val_q  <= val_nxt;
        end
    end

    phs_limit_sel #(
        .CTR_LIM(CTR_LIM),
        .POS_LIM(POS_LIM),
        .DIR_LIM(DIR_LIM)
    ) u_lim (
        .mode  (mode_q),
        .bounds(bounds)
    );

    phs_step_unit u_step (
        .cur        (val_q),
        .en         (step_en),
        .up         (step_up),
        .bounds     (bounds),
        .nxt        (val_nxt),
        .nxt_outside(nxt_outside)
    );

    phs_hold_ctrl #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .nxt_outside(nxt_outside),
        .flag       (ovf_flag)
    );

    assign phase_val = VAL_W'(val_q);
endmodule

// File: rtl/phs_ovf_chk.sv
module phs_ovf_chk
    import phs_pkg::*;
#(
    parameter int CTR_LIM  = 255,
    parameter int POS_LIM  = 255,
    parameter int DIR_LIM  = 1023,
    parameter int HOLD_CYC = 40
) (
    input logic      clk,
    input logic      rst,
    input logic      step_en,
    input logic      step_up,
    input phs_mode_e mode_q,
    input phs_val_t  val_q,
    input logic      ovf_flag
);
    localparam int AGE_W = $clog2(HOLD_CYC + 1);

    phs_bounds_t      bnd;
    logic [AGE_W-1:0] age;

    always_comb bnd = phs_bounds(mode_q, CTR_LIM, POS_LIM, DIR_LIM);

    // cycles the flag has already been high before the current one
    always_ff @(posedge clk) begin
        if (rst || !ovf_flag) age <= '0;
        else if (age != AGE_W'(HOLD_CYC)) age <= age + 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (val_q == '0) && !ovf_flag);

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(val_q));

    a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (val_q == $past(val_q)) ||
                    (val_q == $past(val_q) + phs_val_t'(1)) ||
                    (val_q == $past(val_q) - phs_val_t'(1)));

    a_r5_sat_bounds: assert property (@(posedge clk) disable iff (rst)
        (val_q >= bnd.floor) && (val_q <= bnd.ceil));

    a_r7_outside_flagged: assert property (@(posedge clk) disable iff (rst)
        ((val_q < bnd.lo) || (val_q > bnd.hi)) |-> ovf_flag);

    a_r6_min_hold: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && (age < AGE_W'(HOLD_CYC - 1))) |=> ovf_flag);

    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));
endmodule

bind phs_ovf_tracker phs_ovf_chk #(
    .CTR_LIM (CTR_LIM),
    .POS_LIM (POS_LIM),
    .DIR_LIM (DIR_LIM),
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .step_up (step_up),
    .mode_q  (mode_q),
    .val_q   (val_q),
    .ovf_flag(ovf_flag)
);

// File: tb/sim_phs_ovf_tracker.sv
module sim_phs_ovf_tracker;
    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic        step_en = 1'b0;
    logic        step_up = 1'b0;
    logic [11:0] phase_val;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mode = 0;
    int m_val  = 0;
    int m_flag = 0;
    int m_cnt  = 0;

    always #2 clk = ~clk;

    phs_ovf_tracker u0 (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .step_en  (step_en),
        .step_up  (step_up),
        .phase_val(phase_val),
        .ovf_flag (ovf_flag)
    );

    function automatic int win_lo(int m);
        return (m == 1 || m == 2) ? 0 : -255;
    endfunction
    function automatic int win_hi(int m);
        return (m == 1) ? 255 : (m == 2) ? 1023 : 255;
    endfunction
    function automatic int sat_lo(int m);
        return (m == 1) ? 0 : win_lo(m) - 1;
    endfunction

    task automatic check(string req, int act_v, int act_f);
        checks++;
        if (act_v != m_val || act_f != m_flag) begin
            errors++;
            $display("FAIL %s: val=%0d flag=%0d expected val=%0d flag=%0d",
                     req, act_v, act_f, m_val, m_flag);
        end
    endtask

    task automatic do_reset(int m);
        rst = 1'b1; mode_sel = 2'(m); step_en = 1'b0;
        @(negedge clk);
        m_mode = (m == 3) ? 0 : m; m_val = 0; m_flag = 0; m_cnt = 0;
        check("R1", $signed(phase_val), int'(ovf_flag));
        rst = 1'b0;
    endtask

    task automatic cyc(bit en, bit up, string req);
        int nv;
        bit outside;
        step_en = en; step_up = up;
        nv = m_val;
        if (en && up && m_val < win_hi(m_mode) + 1) nv = m_val + 1;
        if (en && !up && m_val > sat_lo(m_mode)) nv = m_val - 1;
        outside = (nv < win_lo(m_mode)) || (nv > win_hi(m_mode));
        if (m_flag == 0) begin
            if (outside) begin m_flag = 1; m_cnt = HOLD - 1; end
        end else if (m_cnt > 0) m_cnt--;
        else if (!outside) m_flag = 0;
        m_val = nv;
        @(negedge clk);
        check(req, $signed(phase_val), int'(ovf_flag));
    endtask

    task automatic run_random(int n, string req);
        for (int i = 0; i < n; i++) begin
            bit e, u;
            e = ($urandom % 4) != 0;
            u = ($urandom % 8) < 5;
            cyc(e, u, req);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        // R1 and R2: centered window, upper edge
        do_reset(0);
        for (int i = 0; i < 256; i++) cyc(1, 1, "R2");
        for (int i = 0; i < 5; i++) cyc(1, 1, "R5");
        cyc(1, 0, "R6");
        for (int i = 0; i < 45; i++) cyc(0, 0, "R7");
        // R2 lower edge via alias encoding 11
        do_reset(3);
        for (int i = 0; i < 258; i++) cyc(1, 0, "R2");
        for (int i = 0; i < 50; i++) cyc(0, 0, "R7");
        for (int i = 0; i < 3; i++) cyc(1, 1, "R7");
        // R3: positive window
        do_reset(1);
        for (int i = 0; i < 3; i++) cyc(1, 0, "R3");
        for (int i = 0; i < 258; i++) cyc(1, 1, "R3");
        for (int i = 0; i < 60; i++) cyc(0, 0, "R7");
        cyc(1, 0, "R7");
        cyc(0, 1, "R9");
        // R4: direct window, both edges
        do_reset(2);
        cyc(1, 0, "R4");
        cyc(1, 0, "R5");
        for (int i = 0; i < 1030; i++) cyc(1, 1, "R4");
        for (int i = 0; i < 10; i++) cyc(1, 0, "R6");
        for (int i = 0; i < 40; i++) cyc(0, 0, "R7");
        // R8: mode pins changed while running
        do_reset(0);
        mode_sel = 2'b10;
        cyc(1, 0, "R8");
        for (int i = 0; i < 300; i++) cyc(1, 0, "R8");
        mode_sel = 2'b01;
        for (int i = 0; i < 60; i++) cyc(0, 1, "R9");
        // random traffic in every mode
        for (int m = 0; m < 4; m++) begin
            do_reset(m);
            run_random(3000, "R9");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule